// File: doc/BRIEF.md
# Field-programmable phase timing loader

This block lets an operator retune the three phase lengths of a road-junction light sequencer while it runs. Two decimal rotary dials give a setting of 0 to 99 seconds. Each dial's contacts pull lines low, so every digit arrives as the bitwise inverse of its 8421 code. The block turns the digits back into BCD, checks them, and combines them into a seconds value. That value is then stored, as a count of 0.1 s ticks, in one of three duration registers.

A two-bit selector picks the register to update: main-road green, side-road green or yellow. The write takes place once for each press of a load button. The button is assumed to be debounced already; the block synchronises it and acts on its rising edge. The three registers drive a sequencer whose counters run on a 0.1 s tick. Each register holds a terminal count that is one less than the requested number of ticks.

Top module: `phase_timing_loader`

## Requirements
- R1: Each dial digit is read as the bitwise inverse of its 8421 code: raw 1111 decodes to 0, raw 0110 decodes to 9, and raw 1010 decodes to 5.
- R2: The setting in seconds is tens*10 + ones, from 0 to 99. The stored terminal count is seconds*10 - 1, so 99 s stores 989.
- R3: Selector 00 writes the main green register, 01 writes the side green register and 10 writes the yellow register. The two registers that are not selected keep their values.
- R4: A press with selector 11 changes none of the three registers.
- R5: If either decoded digit is above 9 (raw patterns 0000 to 0101), the press is rejected and all three registers keep their values.
- R6: A load happens on the rising edge of the synchronised button. The selected register changes on the third rising clock edge after the button input goes high.
- R7: After reset the terminal counts are 149 for main green (15 s), 99 for side green (10 s) and 49 for yellow (5 s).
- R8: A setting of 0 s is stored as 1 s, which gives a terminal count of 9.
- R9: Holding the button down gives exactly one update. Changes to the dials or the selector while no new press occurs leave all registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dial_tens_n | input | 4 | Tens dial, inverted 8421 code |
| dial_ones_n | input | 4 | Ones dial, inverted 8421 code |
| target_sel | input | 2 | Register selector (00 main, 01 side, 10 yellow, 11 none) |
| load_btn | input | 1 | Debounced load button, active high |
| main_tc | output | 10 | Main green terminal count in 0.1 s ticks |
| side_tc | output | 10 | Side green terminal count in 0.1 s ticks |
| amber_tc | output | 10 | Yellow terminal count in 0.1 s ticks |

## Verification
The bench drives the dials with inverted codes. A design that forgot the inversion would store the complement of every setting, and one that left out the bounds check would accept raw 0000 as decimal 15. The bench holds the button across several changes of the dials and selector. An edge detector that acted on the level would keep rewriting the register, and a wrong synchroniser depth would move the update off the third edge. The 0 s clamp, the unused selector code 11, and the extremes 0 and 99 are each tried. A wrong clamp would give a terminal count that wraps around to all ones. A decode that does not cover all selector codes would write to a register for code 11.

// File: rtl/ptl_pkg.sv
package ptl_pkg;
    localparam int DIGIT_W    = 4;
    localparam int NUM_DIGITS = 2;
    localparam int SEC_W      = 7;
    localparam int TC_W       = 10;

    typedef enum logic [1:0] {
        SEL_MAIN  = 2'b00,
        SEL_SIDE  = 2'b01,
        SEL_AMBER = 2'b10,
        SEL_NONE  = 2'b11
    } target_e;

    typedef struct packed {
        logic [TC_W-1:0] main_tc;
        logic [TC_W-1:0] side_tc;
        logic [TC_W-1:0] amber_tc;
    } phase_regs_t;
endpackage

// File: rtl/btn_edge_sync.sv
module btn_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_in,
    output logic press_pulse
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], btn_in};
        st_d.last  = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign press_pulse = st_q.chain[STAGES-1] & ~st_q.last;

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        press_pulse |=> !press_pulse); // R9
endmodule

// File: rtl/dial_decoder.sv
module dial_decoder
    import ptl_pkg::*;
#(
    parameter int W     = DIGIT_W,
    parameter int N     = NUM_DIGITS,
    parameter int SW    = SEC_W
) (
    input  logic [N-1:0][W-1:0] raw_n,
    output logic [SW-1:0]       seconds,
    output logic                entry_ok
);
    localparam int MAX_DIGIT = 9;

    logic [N-1:0][W-1:0] bcd;
    logic [N-1:0]        digit_ok;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_digit
            assign bcd[g]      = ~raw_n[g];
            assign digit_ok[g] = (bcd[g] <= W'(MAX_DIGIT));
        end
    endgenerate

    always_comb begin
        int acc;
        acc = 0;
        for (int i = N - 1; i >= 0; i--) begin
            acc = acc * 10 + int'(bcd[i]);
        end
        seconds  = SW'(acc);
        entry_ok = &digit_ok;
    end
endmodule

// File: rtl/phase_timing_loader.sv
module phase_timing_loader
    import ptl_pkg::*;
#(
    parameter int TICKS_PER_S = 10,
    parameter int DEF_MAIN_S  = 15,
    parameter int DEF_SIDE_S  = 10,
    parameter int DEF_AMBER_S = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIGIT_W-1:0] dial_tens_n,
    input  logic [DIGIT_W-1:0] dial_ones_n,
    input  logic [1:0]        target_sel,
    input  logic              load_btn,
    output logic [TC_W-1:0]   main_tc,
    output logic [TC_W-1:0]   side_tc,
    output logic [TC_W-1:0]   amber_tc
);
    localparam logic [TC_W-1:0] RST_MAIN  = TC_W'(DEF_MAIN_S * TICKS_PER_S - 1);
    localparam logic [TC_W-1:0] RST_SIDE  = TC_W'(DEF_SIDE_S * TICKS_PER_S - 1);
    localparam logic [TC_W-1:0] RST_AMBER = TC_W'(DEF_AMBER_S * TICKS_PER_S - 1);
    localparam int              MAX_TC    = 99 * TICKS_PER_S - 1;

    logic              press;
    logic [SEC_W-1:0]  secs;
    logic              ok;
    logic [SEC_W-1:0]  secs_eff;
    logic [TC_W-1:0]   new_tc;
    phase_regs_t       regs_d, regs_q;

    btn_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .btn_in     (load_btn),
        .press_pulse(press)
    );

    dial_decoder u_dec (
        .raw_n   ({dial_tens_n, dial_ones_n}),
        .seconds (secs),
        .entry_ok(ok)
    );

    always_comb begin
        secs_eff = (secs == '0) ? SEC_W'(1) : secs;
        new_tc   = TC_W'(int'(secs_eff) * TICKS_PER_S - 1);
        regs_d   = regs_q;
        if (press && ok) begin
            case (target_e'(target_sel))
                SEL_MAIN:  regs_d.main_tc  = new_tc;
                SEL_SIDE:  regs_d.side_tc  = new_tc;
                SEL_AMBER: regs_d.amber_tc = new_tc;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.main_tc  <= RST_MAIN;
            regs_q.side_tc  <= RST_SIDE;
            regs_q.amber_tc <= RST_AMBER;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign main_tc  = regs_q.main_tc;
    assign side_tc  = regs_q.side_tc;
    assign amber_tc = regs_q.amber_tc;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !press |=> $stable(regs_q)); // R9
    AST_SEL_NONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (press && target_sel == 2'b11) |=> $stable(regs_q)); // R4
    AST_BAD_DIGIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (press && !ok) |=> $stable(regs_q)); // R5
    AST_MAIN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (press && target_sel == 2'b00) |=> ($stable(regs_q.side_tc) && $stable(regs_q.amber_tc))); // R3
    AST_NO_ZERO_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (main_tc >= TC_W'(TICKS_PER_S - 1)) && (side_tc >= TC_W'(TICKS_PER_S - 1))
        && (amber_tc >= TC_W'(TICKS_PER_S - 1))); // R8
    AST_TC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (main_tc <= TC_W'(MAX_TC)) && (side_tc <= TC_W'(MAX_TC)) && (amber_tc <= TC_W'(MAX_TC))); // R2
endmodule

// File: tb/tb_phase_timing_loader.sv
module tb_phase_timing_loader;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] dial_tens_n = 4'hF;
    logic [3:0] dial_ones_n = 4'hF;
    logic [1:0] target_sel = 2'b11;
    logic       load_btn = 1'b0;
    logic [9:0] main_tc, side_tc, amber_tc;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    phase_timing_loader dut (
        .clk(clk), .rst_n(rst_n),
        .dial_tens_n(dial_tens_n), .dial_ones_n(dial_ones_n),
        .target_sel(target_sel), .load_btn(load_btn),
        .main_tc(main_tc), .side_tc(side_tc), .amber_tc(amber_tc)
    );

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_all(string req, int m, int s, int a);
        check(req, main_tc, m);
        check(req, side_tc, s);
        check(req, amber_tc, a);
    endtask

    task automatic set_dials(int tens, int ones);
        dial_tens_n = ~4'(tens);
        dial_ones_n = ~4'(ones);
    endtask

    // drive at negedge, press, wait 3 edges, release, settle
    task automatic press(logic [1:0] sel, int tens, int ones);
        @(negedge clk);
        set_dials(tens, ones);
        target_sel = sel;
        load_btn = 1'b1;
        repeat (3) @(negedge clk);
        load_btn = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        check_all("R7 defaults", 149, 99, 49);
    endtask

    task automatic t_select;
        press(2'b00, 4, 2);
        check_all("R3 main R2 42s", 419, 99, 49);
        press(2'b01, 9, 9);
        check_all("R3 side R2 99s", 419, 989, 49);
        press(2'b10, 0, 7);
        check_all("R3 amber R1 07s", 419, 989, 69);
    endtask

    task automatic t_decode;
        // R1: raw 0110 -> 9, raw 1010 -> 5
        @(negedge clk);
        dial_tens_n = 4'b1010;
        dial_ones_n = 4'b0110;
        target_sel  = 2'b00;
        load_btn    = 1'b1;
        repeat (3) @(negedge clk);
        load_btn = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 raw decode 59", main_tc, 589);
    endtask

    task automatic t_timing;
        // R6: unchanged after two edges, updated after the third
        @(negedge clk);
        set_dials(2, 0);
        target_sel = 2'b01;
        load_btn = 1'b1;
        repeat (2) @(negedge clk);
        check("R6 not before third edge", side_tc, 989);
        @(negedge clk);
        check("R6 at third edge", side_tc, 199);
        // R9: held button, dials move, no second write
        set_dials(3, 3);
        repeat (5) @(negedge clk);
        target_sel = 2'b00;
        repeat (5) @(negedge clk);
        check_all("R9 held button single write", 589, 199, 69);
        load_btn = 1'b0;
        repeat (4) @(negedge clk);
        set_dials(1, 1);
        target_sel = 2'b10;
        repeat (6) @(negedge clk);
        check_all("R9 idle dial change", 589, 199, 69);
    endtask

    task automatic t_reject;
        press(2'b11, 5, 5);
        check_all("R4 selector 11 ignored", 589, 199, 69);
        @(negedge clk);
        dial_tens_n = 4'b0000;   // decodes to 15
        dial_ones_n = 4'b1110;
        target_sel  = 2'b00;
        load_btn    = 1'b1;
        repeat (3) @(negedge clk);
        load_btn = 1'b0;
        repeat (4) @(negedge clk);
        check_all("R5 tens digit above 9", 589, 199, 69);
        @(negedge clk);
        dial_tens_n = 4'b1111;
        dial_ones_n = 4'b0101;   // decodes to 10
        target_sel  = 2'b10;
        load_btn    = 1'b1;
        repeat (3) @(negedge clk);
        load_btn = 1'b0;
        repeat (4) @(negedge clk);
        check_all("R5 ones digit above 9", 589, 199, 69);
    endtask

    task automatic t_clamp;
        press(2'b10, 0, 0);
        check("R8 zero clamped to 1s", amber_tc, 9);
        press(2'b00, 0, 1);
        check("R8 one second", main_tc, 9);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_select();
        t_decode();
        t_timing();
        t_reject();
        t_clamp();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule